// File: doc/BRIEF.md
# Rounding and Saturating Width Reducer

This block takes a wide signed two's-complement fixed-point word and returns a narrower one. It drops fractional bits from the bottom and integer bits from the top. The number of bits kept in each part is set by parameters. Low bits are removed in one of two ways, chosen by a mode input on every sample. Truncation mode discards them, which rounds toward minus infinity. Rounding mode rounds to the nearest output step, with ties moving away from zero. This avoids the steady negative offset that plain slicing leaves in a signal.

High bits are removed after the rounding adjustment. When the result does not fit the narrow range, the output is clamped to the largest or smallest code the output can hold. A valid flag travels through the pipeline beside the data. The pipeline has two register stages:

- The first stage registers the kept bits together with a one-bit increment decision, which comes from comparing the discarded bits against one half.
- The second stage adds that increment, checks the bits that will be removed, and registers the clamped result.

With the default parameters the input has 16 bits, 12 of them fractional. The output has 8 bits, 5 of them fractional. Each step drops 7 low bits and 1 high bit.

Top module: `fxr_narrow`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `out_vld` is 0 and `out_data` is all zeros.
- R2: `out_vld` equals the value `in_vld` had two clock edges earlier, and the sample taken with it appears on `out_data` at that same edge.
- R3: With `rnd_mode` = 0 (truncation), the result is the input shifted right arithmetically by the dropped fractional count (floor), before clamping.
- R4: With `rnd_mode` = 1 and a non-negative input, the result is increased by one output LSB exactly when the discarded bits are at least one half (top discarded bit 1); a tie rounds up.
- R5: With `rnd_mode` = 1 and a negative input, the floor result is increased by one LSB only when the discarded bits exceed one half; a tie stays at the floor, moving away from zero.
- R6: A result above the output range is replaced by 0 followed by all ones (0x7F with defaults).
- R7: A result below the output range is replaced by 1 followed by all zeros (0x80 with defaults).
- R8: A rounding increment that carries the kept value past the largest output code is clamped to that code, not wrapped.
- R9: A result that fits the output range, including the exact minimum and maximum codes, passes unclamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Wide signed fixed-point input |
| rnd_mode | input | 1 | 0 selects truncation, 1 selects round-to-nearest |
| out_vld | output | 1 | Output sample qualifier, two cycles after `in_vld` |
| out_data | output | OUT_W | Narrow signed fixed-point result |

## Verification
The bench targets the exact half-way points for both signs. A design with the wrong tie direction, or one that rounds negatives symmetrically, lands one step off there. It also drives inputs just below the top of the range with a rounding carry: a design that clamps before the add wraps those to the most negative code. Values one step beyond either end of the range, together with the exact extremes, catch an off-by-one in the overflow test, and random traffic with gaps in `in_vld` exposes any latency slip between the flag and the data.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_NEAR  = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/fxr_round_stage.sv
module fxr_round_stage
    import fxr_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int LO_DROP = 7,
    localparam int KEEP_W = IN_W - LO_DROP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [IN_W-1:0]   din,
    input  rnd_mode_e         mode,
    output logic              vld_q,
    output logic [KEEP_W-1:0] kept_q,
    output logic              inc_q
);

    logic inc_d;

    generate
        if (LO_DROP == 0) begin : g_pass
            assign inc_d = 1'b0;
        end else begin : g_cmp
            logic half_bit;
            logic rest_nz;
            assign half_bit = din[LO_DROP-1];
            if (LO_DROP == 1) begin : g_norest
                assign rest_nz = 1'b0;
            end else begin : g_rest
                assign rest_nz = |din[LO_DROP-2:0];
            end
            // tie: positive goes up, negative stays at floor (away from zero)
            assign inc_d = (mode == RND_NEAR) && half_bit &&
                           (!din[IN_W-1] || rest_nz);

            // R4
            below_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_i && !din[LO_DROP-1]) |=> !inc_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            kept_q <= '0;
            inc_q  <= 1'b0;
        end else begin
            vld_q  <= vld_i;
            kept_q <= din[IN_W-1:LO_DROP];
            inc_q  <= inc_d;
        end
    end

    // R3
    trunc_noinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode == RND_TRUNC) |=> !inc_q);

    // R2
    vld_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_q);

endmodule

// File: rtl/fxr_sat_stage.sv
module fxr_sat_stage #(
    parameter int KEEP_W = 9,
    parameter int OUT_W  = 8,
    localparam int SUM_W  = KEEP_W + 1,
    localparam int TOP_W  = SUM_W - OUT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [KEEP_W-1:0] kept,
    input  logic              inc,
    output logic              vld_q,
    output logic [OUT_W-1:0]  dout_q
);

    localparam logic [OUT_W-1:0] CODE_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] CODE_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;
    logic [TOP_W-1:0] top_bits;
    logic             fits;
    logic [OUT_W-1:0] dout_d;

    always_comb begin
        sum      = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, inc};
        top_bits = sum[SUM_W-1:OUT_W-1];
        fits     = (&top_bits) || !(|top_bits);
        if (fits) begin
            dout_d = sum[OUT_W-1:0];
        end else if (sum[SUM_W-1]) begin
            dout_d = CODE_MIN;
        end else begin
            dout_d = CODE_MAX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            vld_q  <= vld_i;
            dout_q <= dout_d;
        end
    end

    // R6
    pos_keeps_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !kept[KEEP_W-1]) |=> !dout_q[OUT_W-1]);

    // R7
    neg_keeps_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && kept[KEEP_W-1] && !inc) |=> dout_q[OUT_W-1]);

    // R8
    carry_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && inc && kept == {1'b0, CODE_MAX}) |=> dout_q == CODE_MAX);

    // R2
    vld_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_q);

endmodule

// File: rtl/fxr_narrow.sv
module fxr_narrow
    import fxr_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int IN_FRAC  = 12,
    parameter int OUT_W    = 8,
    parameter int OUT_FRAC = 5,
    localparam int LO_DROP = IN_FRAC - OUT_FRAC,
    localparam int KEEP_W  = IN_W - LO_DROP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_data,
    input  logic             rnd_mode,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_data
);

    logic              mid_vld;
    logic [KEEP_W-1:0] mid_kept;
    logic              mid_inc;
    rnd_mode_e         mode_sel;

    assign mode_sel = rnd_mode_e'(rnd_mode);

    fxr_round_stage #(
        .IN_W    (IN_W),
        .LO_DROP (LO_DROP)
    ) u_round (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .din    (in_data),
        .mode   (mode_sel),
        .vld_q  (mid_vld),
        .kept_q (mid_kept),
        .inc_q  (mid_inc)
    );

    fxr_sat_stage #(
        .KEEP_W (KEEP_W),
        .OUT_W  (OUT_W)
    ) u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (mid_vld),
        .kept   (mid_kept),
        .inc    (mid_inc),
        .vld_q  (out_vld),
        .dout_q (out_data)
    );

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld || !rst_n));

endmodule

// File: tb/sim_fxr_narrow.sv
module sim_fxr_narrow;

    localparam int IN_W     = 16;
    localparam int IN_FRAC  = 12;
    localparam int OUT_W    = 8;
    localparam int OUT_FRAC = 5;
    localparam int D        = IN_FRAC - OUT_FRAC;
    localparam int HALF     = 1 << (D - 1);
    localparam int OMAX     = (1 << (OUT_W - 1)) - 1;
    localparam int OMIN     = -(1 << (OUT_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             rnd_mode = 1'b0;
    logic             out_vld;
    logic [OUT_W-1:0] out_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    e_v [2];
    int    e_d [2];
    string e_t [2];

    always #5 clk = ~clk;

    fxr_narrow #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .rnd_mode(rnd_mode), .out_vld(out_vld), .out_data(out_data)
    );

    function automatic int model(int x, bit rnd, output string tag);
        int t, f, inc, r;
        t   = x >>> D;
        f   = x & ((1 << D) - 1);
        inc = 0;
        if (rnd) inc = (x >= 0) ? int'(f >= HALF) : int'(f > HALF);
        r = t + inc;
        if (r > OMAX) begin
            tag = (inc == 1 && t == OMAX) ? "R8" : "R6";
            r = OMAX;
        end else if (r < OMIN) begin
            tag = "R7";
            r = OMIN;
        end else if (rnd && f == HALF) begin
            tag = (x >= 0) ? "R4" : "R5";
        end else if (!rnd) begin
            tag = "R3";
        end else if (r == OMAX || r == OMIN) begin
            tag = "R9";
        end else begin
            tag = (x >= 0) ? "R4" : "R5";
        end
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: compare outputs, advance the model pipeline, drive new input
    task automatic step(bit v, int x, bit rnd);
        string tg;
        int    y;
        @(negedge clk);
        check("R2", int'(out_vld), int'(e_v[1]));
        if (e_v[1]) check(e_t[1], int'($signed(out_data)), e_d[1]);
        e_v[1] = e_v[0]; e_d[1] = e_d[0]; e_t[1] = e_t[0];
        y = model(x, rnd, tg);
        e_v[0] = v; e_d[0] = y; e_t[0] = tg;
        in_vld   = v;
        in_data  = IN_W'(x);
        rnd_mode = rnd;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        e_v[0] = 0; e_v[1] = 0; e_d[0] = 0; e_d[1] = 0;
        e_t[0] = "R2"; e_t[1] = "R2";
        in_vld = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle during reset even with in_vld high
        check("R1", int'(out_vld), 0);
        check("R1", int'(out_data), 0);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        check("R1", int'(out_vld), 0);
        // R3 truncation floors
        step(1, -1, 0);
        step(1, 64, 0);
        step(1, 16320, 0);
        // R4 positive tie and below half
        step(1, 64, 1);
        step(1, 63, 1);
        // R5 negative tie, above and below half magnitude
        step(1, -64, 1);
        step(1, -63, 1);
        step(1, -65, 1);
        step(1, -1, 1);
        // R8 rounding carry at top of range
        step(1, 16320, 1);
        // R6 / R7 clamps
        step(1, 20000, 1);
        step(1, -20000, 0);
        step(1, 32767, 0);
        step(1, -32768, 1);
        // R9 exact extremes and just past them
        step(1, -16384, 0);
        step(1, -16385, 1);
        step(1, -16385, 0);
        step(1, 16256, 0);
        step(1, 16383, 0);
        // R2 gaps in valid
        step(0, 100, 1);
        step(1, 200, 1);
        step(0, 300, 0);
        step(0, 400, 0);
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, int'($signed(16'($urandom))), $urandom % 2);
        end
        for (int i = 0; i < 3; i++) step(0, 0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule